// File: doc/BRIEF.md
# Strap-Selectable Address Region Decoder

This block sits between a 32-bit word-address requester and the targets of a processor's address space. For every valid request it chooses exactly one target: the internal boot ROM, the peripheral register space, either of two 1K-word on-chip RAM blocks, the local external bus or the global external bus. For an external target it also produces the address that goes out on that bus's pins. Addresses that fall into reserved holes raise an error and select nothing. All outputs are registered and appear in the clock cycle after the request.

A strap input decides how the lowest megaword is used. With the strap high, the boot ROM sits at the bottom of that megaword and the remainder is a reserved hole. With the strap low, the whole megaword belongs to the local bus. A build parameter selects a reduced-pin variant in which each external bus drives only 24 address pins. On that variant each 2G-word external half of the map repeats its first 16M words.

Top module: `mmap_decoder`

## Requirements
- R1: After reset, and in the cycle after any cycle with `req_valid` low, `sel` is 0, `rsv_err` is 0 and `ext_addr` is 0. A request presented in one cycle shows its result in the next cycle only.
- R2: With `rom_strap` = 1, an address in the first megaword whose low 20 bits are below ROM_WORDS (default 4096) sets `sel` bit 0 (boot ROM).
- R3: With `rom_strap` = 1, an address in the first megaword at or above ROM_WORDS sets `rsv_err` and leaves `sel` at 0.
- R4: With `rom_strap` = 0, any address in 0000_0000h to 000F_FFFFh sets `sel` bit 4 (local bus), and `ext_addr` equals the request address.
- R5: Addresses 0010_0000h to 001F_FFFFh set `sel` bit 1 (peripherals) whatever the strap level.
- R6: Addresses 002F_F800h to 002F_FBFFh set `sel` bit 2 (RAM block 0). Addresses 002F_FC00h to 002F_FFFFh set `sel` bit 3 (RAM block 1).
- R7: Any other address in 0020_0000h to 002F_FFFFh sets `rsv_err` and leaves `sel` at 0.
- R8: Addresses 0030_0000h to 7FFF_FFFFh set `sel` bit 4 (local bus). On the full variant (NARROW = 0), `ext_addr` is the low 31 address bits.
- R9: Addresses 8000_0000h to FFFF_FFFFh set `sel` bit 5 (global bus). On the full variant, `ext_addr` is the low 31 address bits.
- R10: On the narrow variant (NARROW = 1), `ext_addr` for a local or global select is the low 24 address bits, and bits 30:24 are 0. Each external half therefore aliases every 16M words.
- R11: `ext_addr` is 0 whenever neither `sel` bit 4 nor `sel` bit 5 is set. At most one `sel` bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Word address of the request |
| rom_strap | input | 1 | 1: boot ROM in the first megaword; 0: first megaword on the local bus |
| sel | output | 6 | One-hot target: 0 ROM, 1 peripherals, 2 RAM0, 3 RAM1, 4 local bus, 5 global bus |
| ext_addr | output | 31 | Address driven onto the selected external bus |
| rsv_err | output | 1 | The request hit a reserved hole |

## Verification
A wrong region boundary shows in the cycle after the request. It appears as the wrong select bit, or as a missing or spurious reserved error, at an address next to that boundary. For that reason the directed tests probe the first and last word of every region. A wrong address mask on the narrow variant shows as nonzero upper `ext_addr` bits, or as a failed wrap, on the very next cycle. A stale output register shows up as a select that remains set in the cycle after an idle input.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

    localparam int ADDR_W  = 32;
    localparam int EXTA_W  = 31;
    localparam int MW_BITS = 20;
    localparam int NUM_TGT = 6;

    typedef enum logic [2:0] {
        TGT_NONE   = 3'd0,
        TGT_ROM    = 3'd1,
        TGT_PERIPH = 3'd2,
        TGT_RAM0   = 3'd3,
        TGT_RAM1   = 3'd4,
        TGT_LOCAL  = 3'd5,
        TGT_GLOBAL = 3'd6,
        TGT_RSV    = 3'd7
    } target_e;

    typedef struct packed {
        logic [NUM_TGT-1:0] sel;
        logic [EXTA_W-1:0]  ext;
        logic               err;
    } dec_out_t;

    function automatic logic [NUM_TGT-1:0] tgt_onehot(input target_e t);
        logic [NUM_TGT-1:0] v;
        v = '0;
        case (t)
            TGT_ROM:    v[0] = 1'b1;
            TGT_PERIPH: v[1] = 1'b1;
            TGT_RAM0:   v[2] = 1'b1;
            TGT_RAM1:   v[3] = 1'b1;
            TGT_LOCAL:  v[4] = 1'b1;
            TGT_GLOBAL: v[5] = 1'b1;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic logic tgt_is_ext(input target_e t);
        return (t == TGT_LOCAL) || (t == TGT_GLOBAL);
    endfunction

endpackage

// File: rtl/mmap_region_classify.sv
module mmap_region_classify
    import mmap_pkg::*;
#(
    parameter int ROM_WORDS = 4096,
    parameter logic [31:0] RAM_BASE = 32'h002F_F800,
    parameter int RAM_WORDS = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              strap,
    output target_e           tgt
);
    localparam int MW_IDX_W = ADDR_W - MW_BITS;
    localparam logic [ADDR_W-1:0] RAM1_BASE = RAM_BASE + ADDR_W'(RAM_WORDS);
    localparam logic [ADDR_W-1:0] RAM_END   = RAM_BASE + ADDR_W'(2 * RAM_WORDS);

    logic [MW_IDX_W-1:0] mw;
    logic [MW_BITS-1:0]  mw_off;
    logic                in_rom;
    logic                in_ram0;
    logic                in_ram1;

    assign mw      = addr[ADDR_W-1:MW_BITS];
    assign mw_off  = addr[MW_BITS-1:0];
    assign in_rom  = (mw_off < MW_BITS'(ROM_WORDS));
    assign in_ram0 = (addr >= RAM_BASE)  && (addr < RAM1_BASE);
    assign in_ram1 = (addr >= RAM1_BASE) && (addr < RAM_END);

    always_comb begin
        if (addr[ADDR_W-1]) begin
            tgt = TGT_GLOBAL;
        end else if (mw == MW_IDX_W'(0)) begin
            if (strap) tgt = in_rom ? TGT_ROM : TGT_RSV;
            else       tgt = TGT_LOCAL;
        end else if (mw == MW_IDX_W'(1)) begin
            tgt = TGT_PERIPH;
        end else if (mw == MW_IDX_W'(2)) begin
            if (in_ram0)      tgt = TGT_RAM0;
            else if (in_ram1) tgt = TGT_RAM1;
            else              tgt = TGT_RSV;
        end else begin
            tgt = TGT_LOCAL;
        end
    end

endmodule

// File: rtl/mmap_ext_xlate.sv
module mmap_ext_xlate
    import mmap_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  target_e           tgt,
    output logic [EXTA_W-1:0] ext
);
    localparam int PIN_W = NARROW ? 24 : EXTA_W;

    logic [EXTA_W-1:0] masked;

    generate
        if (PIN_W < EXTA_W) begin : g_narrow
            assign masked = {{(EXTA_W-PIN_W){1'b0}}, addr[PIN_W-1:0]};
        end else begin : g_full
            assign masked = addr[EXTA_W-1:0];
        end
    endgenerate

    assign ext = tgt_is_ext(tgt) ? masked : '0;

endmodule

// File: rtl/mmap_out_reg.sv
module mmap_out_reg
    import mmap_pkg::*;
#(
    parameter bit NARROW = 1'b0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     vld,
    input  dec_out_t d,
    output dec_out_t q
);
    always_ff @(posedge clk) begin
        if (rst || !vld) q <= '0;
        else             q <= d;
    end

    AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        q.err |-> (q.sel == '0)); // R7

    generate
        if (NARROW) begin : g_chk_narrow
            AST_NARROW_PINS: assert property (@(posedge clk) disable iff (rst)
                q.ext[EXTA_W-1:24] == '0); // R10
        end
    endgenerate

endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter bit NARROW = 1'b0,
    parameter int ROM_WORDS = 4096,
    parameter logic [31:0] RAM_BASE = 32'h002F_F800,
    parameter int RAM_WORDS = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        rom_strap,
    output logic [5:0]  sel,
    output logic [30:0] ext_addr,
    output logic        rsv_err
);
    target_e  tgt;
    dec_out_t nxt;
    dec_out_t cur;

    mmap_region_classify #(
        .ROM_WORDS(ROM_WORDS), .RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS)
    ) u_cls (
        .addr(req_addr), .strap(rom_strap), .tgt(tgt)
    );

    mmap_ext_xlate #(.NARROW(NARROW)) u_xl (
        .addr(req_addr), .tgt(tgt), .ext(nxt.ext)
    );

    assign nxt.sel = tgt_onehot(tgt);
    assign nxt.err = (tgt == TGT_RSV);

    mmap_out_reg #(.NARROW(NARROW)) u_reg (
        .clk(clk), .rst(rst), .vld(req_valid), .d(nxt), .q(cur)
    );

    assign sel      = cur.sel;
    assign ext_addr = cur.ext;
    assign rsv_err  = cur.err;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (sel == '0) && !rsv_err); // R1
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R11
    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sel[5:4] == 2'b00) |-> (ext_addr == '0)); // R11
    AST_NO_ROM_STRAP_LOW: assert property (@(posedge clk) disable iff (rst)
        req_valid && !rom_strap |=> !sel[0]); // R4
    AST_GLOBAL_HALF: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_addr[31] |=> sel[5]); // R9

endmodule

// File: tb/mmap_decoder_tb.sv
module mmap_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rom_strap = 1'b0;
    logic [5:0]  sel_f, sel_n;
    logic [30:0] ext_f, ext_n;
    logic        err_f, err_n;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mmap_decoder #(.NARROW(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rom_strap(rom_strap), .sel(sel_f), .ext_addr(ext_f), .rsv_err(err_f)
    );

    mmap_decoder #(.NARROW(1'b1)) u_dut_nar (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .rom_strap(rom_strap), .sel(sel_n), .ext_addr(ext_n), .rsv_err(err_n)
    );

    task automatic chk(input string tag, input bit narrow, input logic [5:0] es,
                       input logic [30:0] ee, input logic er);
        logic [5:0] s; logic [30:0] e; logic r;
        s = narrow ? sel_n : sel_f;
        e = narrow ? ext_n : ext_f;
        r = narrow ? err_n : err_f;
        checks++;
        if (s !== es || e !== ee || r !== er) begin
            errors++;
            $display("FAIL %s narrow=%0d addr=%h sel=%b/%b ext=%h/%h err=%b/%b (actual/expected)",
                     tag, narrow, req_addr, s, es, e, ee, r, er);
        end
    endtask

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic req(input logic [31:0] a, input logic strap);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; rom_strap = strap;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 reset", 0, 6'b0, '0, 1'b0);
        chk("R1 reset", 1, 6'b0, '0, 1'b0);
    endtask

    task automatic t_rom;
        req(32'h0000_0000, 1'b1); chk("R2 rom low", 0, 6'b000001, '0, 1'b0);
        req(32'h0000_0FFF, 1'b1); chk("R2 rom top", 0, 6'b000001, '0, 1'b0);
        req(32'h0000_1000, 1'b1); chk("R3 above rom", 0, 6'b0, '0, 1'b1);
        req(32'h000F_FFFF, 1'b1); chk("R3 mw end", 0, 6'b0, '0, 1'b1);
    endtask

    task automatic t_strap_low;
        req(32'h0000_0000, 1'b0); chk("R4 first", 0, 6'b010000, 31'h0, 1'b0);
        req(32'h000A_BCDE, 1'b0); chk("R4 mid", 0, 6'b010000, 31'h000A_BCDE, 1'b0);
        req(32'h000F_FFFF, 1'b0); chk("R4 last", 1, 6'b010000, 31'h000F_FFFF, 1'b0);
    endtask

    task automatic t_periph;
        req(32'h0010_0000, 1'b0); chk("R5 low", 0, 6'b000010, '0, 1'b0);
        req(32'h001F_FFFF, 1'b1); chk("R5 high strap1", 0, 6'b000010, '0, 1'b0);
    endtask

    task automatic t_ram;
        req(32'h002F_F800, 1'b0); chk("R6 ram0 low", 0, 6'b000100, '0, 1'b0);
        req(32'h002F_FBFF, 1'b0); chk("R6 ram0 high", 0, 6'b000100, '0, 1'b0);
        req(32'h002F_FC00, 1'b1); chk("R6 ram1 low", 0, 6'b001000, '0, 1'b0);
        req(32'h002F_FFFF, 1'b1); chk("R6 ram1 high", 1, 6'b001000, '0, 1'b0);
    endtask

    task automatic t_hole;
        req(32'h0020_0000, 1'b0); chk("R7 hole low", 0, 6'b0, '0, 1'b1);
        req(32'h002F_F7FF, 1'b0); chk("R7 below ram", 0, 6'b0, '0, 1'b1);
        chk("R7 below ram", 1, 6'b0, '0, 1'b1);
    endtask

    task automatic t_external;
        req(32'h0030_0000, 1'b0); chk("R8 local first", 0, 6'b010000, 31'h0030_0000, 1'b0);
        req(32'h7FFF_FFFF, 1'b0); chk("R8 local last", 0, 6'b010000, 31'h7FFF_FFFF, 1'b0);
        req(32'h8000_0000, 1'b1); chk("R9 global first", 0, 6'b100000, 31'h0, 1'b0);
        req(32'hFFFF_FFFF, 1'b0); chk("R9 global last", 0, 6'b100000, 31'h7FFF_FFFF, 1'b0);
    endtask

    task automatic t_narrow;
        req(32'h0130_0000, 1'b0); chk("R10 local alias", 1, 6'b010000, 31'h0030_0000, 1'b0);
        chk("R8 full no alias", 0, 6'b010000, 31'h0130_0000, 1'b0);
        req(32'h7FFF_FFFF, 1'b0); chk("R10 local wrap", 1, 6'b010000, 31'h00FF_FFFF, 1'b0);
        req(32'h8123_4567, 1'b0); chk("R10 global alias", 1, 6'b100000, 31'h0023_4567, 1'b0);
        req(32'h0100_0000, 1'b0); chk("R10 alias zero", 1, 6'b010000, 31'h0, 1'b0);
    endtask

    task automatic t_idle;
        req(32'h8000_1234, 1'b0); chk("R11 pre idle", 0, 6'b100000, 31'h0000_1234, 1'b0);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle", 0, 6'b0, '0, 1'b0);
        chk("R1 idle", 1, 6'b0, '0, 1'b0);
        req(32'h0010_0004, 1'b0); chk("R11 ext zero non-ext", 0, 6'b000010, '0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rom();
        t_strap_low();
        t_periph();
        t_ram();
        t_hole();
        t_external();
        t_narrow();
        t_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule